// File: doc/BRIEF.md
# Selective Replay Dependence Tracker

This block sits beside an out-of-order scheduler. It records, for every waiting or issued instruction, which unverified loads it depends on, so that a load miss replays only the true dependents. Dependence is held as a small bit matrix per source operand. A column stands for one memory-pipeline issue slot and a row stands for one cycle of the load's verification delay. When a load issues, it seeds a fresh bit in its slot's column. Any instruction that issues passes the union of its sources' matrices on a dependence bus next to its result tag. Consumers waking on that tag take the matrix over, so dependence is carried through any number of levels.

Every cycle each stored matrix moves one row toward the last row. The last row is reached exactly when the load that set the bit is verified. A miss is reported on a kill vector with one bit per memory slot. Every source whose last-row bit in a killed column is set becomes unready again, and its instruction loses its issued mark so that it can be selected again. Instructions with no bit in a killed column carry on. On a hit nothing is signalled: the bit moves out of the last row and is lost. Selection itself is outside the block. The caller names the entry to issue, and the block accepts it only when that entry is requesting.

Top module: `dep_replay_tracker`

## Requirements
- R1: After synchronous reset, `req_vec` and `issued_vec` are all zero and `bcast_valid` is low.
- R2: An allocated entry whose sources are all ready drives its `req_vec` bit from the next cycle on. An issue naming an entry that is not requesting is ignored: `bcast_valid` stays low and no state changes. An accepted issue raises `bcast_valid` with the entry's destination tag in the same cycle, and sets the entry's `issued_vec` bit from the next cycle.
- R3: In the cycle a load issues on memory slot `s`, `bcast_mtx` has bit `s` set. Bit `r*SLOTS+s` stands for row `r` and slot `s`, and row 0 is the newest.
- R4: A waiting source whose tag equals `bcast_tag` while `bcast_valid` is high becomes ready from the next cycle and takes `bcast_mtx` as its matrix. When that consumer later issues, it broadcasts its inherited bits aged by the cycles that have passed, so dependence spans several levels.
- R5: Stored matrices advance one row per cycle. A bit seeded by a load issued in cycle t lies in the last row (row ROWS-1, default row 2) in cycle t+ROWS.
- R6: When `kill_vec` bit `s` is high in a cycle, every source whose last-row bit `s` is set becomes unready, and its entry's `issued_vec` bit clears, from the next cycle. A kill on a column in which no source has a last-row bit set has no effect.
- R7: Entries with no last-row bit in a killed column keep their ready and issued state across the kill.
- R8: A bit that leaves the last row without a kill is dropped. A later kill on that column has no effect on the entry, and a broadcast made after that point carries no bit from it.
- R9: An entry that is killed in the same cycle it is named for issue is not issued: `bcast_valid` stays low and its `issued_vec` bit stays clear.
- R10: Allocation overwrites an entry and clears its issued mark. Freeing an entry clears its `req_vec` and `issued_vec` bits from the next cycle.
- R11: A killed source becomes ready again when its producer's tag is broadcast again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Write a new instruction into an entry |
| alloc_idx | input | IDX_W | Entry to write |
| alloc_tag | input | TAG_W | Destination tag of the new instruction |
| alloc_is_load | input | 1 | New instruction is a load |
| alloc_src_tag | input | SRCS*TAG_W | Source tags, source i at bits [i*TAG_W +: TAG_W] |
| alloc_src_rdy | input | SRCS | Source already verified and ready |
| issue_valid | input | 1 | Selection names an entry this cycle |
| issue_idx | input | IDX_W | Entry being issued |
| issue_slot | input | SLOT_W | Memory slot used when the entry is a load |
| free_valid | input | 1 | Release an entry |
| free_idx | input | IDX_W | Entry to release |
| kill_vec | input | SLOTS | Miss report, one bit per memory slot |
| req_vec | output | ENTRIES | Entry is valid, not issued and all sources ready |
| issued_vec | output | ENTRIES | Entry is issued and not yet invalidated |
| bcast_valid | output | 1 | An issue was accepted this cycle |
| bcast_tag | output | TAG_W | Tag of the issuing instruction |
| bcast_mtx | output | ROWS*SLOTS | Dependence matrix sent with the tag |

## Verification
The broadcast outputs are combinational in the issue cycle, so the bench checks them 1 ns after it drives the inputs. `req_vec` and `issued_vec` are due one edge after allocation, issue, wakeup, kill or free, and the bench pushes that expectation into its queue before the edge. A monitor pops it 1 ns after the edge. The kill cases are placed by counting cycles from the load's issue: the kill falls in cycle t+3 for the default depth so that it meets the last row, and in cycle t+4 to show a bit that has already left. A further case fires a kill on the wrong column while a bit sits in the last row.

// File: rtl/sr_pkg.sv
package sr_pkg;

    localparam int SR_ROWS   = 3;
    localparam int SR_SLOTS  = 2;
    localparam int SR_TAG_W  = 4;
    localparam int SR_SRCS   = 2;
    localparam int SR_SLOT_W = (SR_SLOTS > 1) ? $clog2(SR_SLOTS) : 1;

    typedef logic [SR_ROWS-1:0][SR_SLOTS-1:0] mtx_t;
    typedef logic [SR_TAG_W-1:0]              tag_t;

    typedef struct packed {
        logic rdy;
        tag_t tag;
        mtx_t mtx;
    } src_t;

    // Move every row one step toward verification; row 0 becomes empty.
    function automatic mtx_t age_mtx(input mtx_t m);
        mtx_t r;
        r = '0;
        for (int i = 1; i < SR_ROWS; i++) begin
            r[i] = m[i-1];
        end
        return r;
    endfunction

    // Fresh dependence bit for a load issued on a memory slot.
    function automatic mtx_t seed_mtx(input logic [SR_SLOT_W-1:0] slot);
        mtx_t r;
        r = '0;
        r[0][slot] = 1'b1;
        return r;
    endfunction

    function automatic logic last_row_hit(input mtx_t m, input logic [SR_SLOTS-1:0] kv);
        return |(m[SR_ROWS-1] & kv);
    endfunction

endpackage

// File: rtl/sr_src_track.sv
module sr_src_track
    import sr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  tag_t                load_tag,
    input  logic                load_rdy,
    input  logic                bc_valid,
    input  tag_t                bc_tag,
    input  mtx_t                bc_mtx,
    input  logic [SR_SLOTS-1:0] kill_vec,
    output src_t                st,
    output logic                kill_hit
);

    logic wake;

    assign kill_hit = last_row_hit(st.mtx, kill_vec);
    assign wake     = bc_valid && !st.rdy && (st.tag == bc_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (load) begin
            st <= '{rdy: load_rdy, tag: load_tag, mtx: '0};
        end else if (kill_hit) begin
            st.rdy <= 1'b0;
            st.mtx <= '0;
        end else if (wake) begin
            st.rdy <= 1'b1;
            st.mtx <= bc_mtx;
        end else begin
            st.mtx <= age_mtx(st.mtx);
        end
    end

    assert_kill_unready_R6: assert property (@(posedge clk) disable iff (rst)
        (kill_hit && !load) |=> !st.rdy);

    assert_wake_ready_R4: assert property (@(posedge clk) disable iff (rst)
        (wake && !kill_hit && !load) |=> st.rdy);

    assert_unready_clean_R6: assert property (@(posedge clk) disable iff (rst)
        !st.rdy |-> (st.mtx == '0));

    assert_row_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && !kill_hit && !wake) |=> (st.mtx[SR_ROWS-1] == $past(st.mtx[SR_ROWS-2])));

endmodule

// File: rtl/sr_sched_entry.sv
module sr_sched_entry
    import sr_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              alloc_we,
    input  tag_t                              alloc_tag,
    input  logic                              alloc_is_load,
    input  logic [SR_SRCS-1:0][SR_TAG_W-1:0]  alloc_src_tag,
    input  logic [SR_SRCS-1:0]                alloc_src_rdy,
    input  logic                              issue_go,
    input  logic                              free_we,
    input  logic                              bc_valid,
    input  tag_t                              bc_tag,
    input  mtx_t                              bc_mtx,
    input  logic [SR_SLOTS-1:0]               kill_vec,
    output logic                              req,
    output logic                              issued,
    output logic                              is_load,
    output tag_t                              dest_tag,
    output mtx_t                              src_or,
    output logic                              killed
);

    logic               valid;
    src_t               src_q [SR_SRCS];
    logic [SR_SRCS-1:0] hit;
    logic               all_rdy;

    for (genvar s = 0; s < SR_SRCS; s++) begin : g_src
        sr_src_track u_src (
            .clk      (clk),
            .rst      (rst),
            .load     (alloc_we),
            .load_tag (alloc_src_tag[s]),
            .load_rdy (alloc_src_rdy[s]),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_mtx   (bc_mtx),
            .kill_vec (kill_vec),
            .st       (src_q[s]),
            .kill_hit (hit[s])
        );
    end

    always_comb begin
        all_rdy = 1'b1;
        src_or  = '0;
        for (int s = 0; s < SR_SRCS; s++) begin
            all_rdy = all_rdy & src_q[s].rdy;
            src_or  = src_or | src_q[s].mtx;
        end
    end

    assign killed = valid && (|hit);
    assign req    = valid && !issued && all_rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            issued   <= 1'b0;
            is_load  <= 1'b0;
            dest_tag <= '0;
        end else if (alloc_we) begin
            valid    <= 1'b1;
            issued   <= 1'b0;
            is_load  <= alloc_is_load;
            dest_tag <= alloc_tag;
        end else if (free_we) begin
            valid    <= 1'b0;
            issued   <= 1'b0;
        end else if (killed) begin
            issued   <= 1'b0;
        end else if (issue_go) begin
            issued   <= 1'b1;
        end
    end

    assert_issue_marks_R2: assert property (@(posedge clk) disable iff (rst)
        (issue_go && !alloc_we && !free_we) |=> issued);

    assert_kill_reopens_R6: assert property (@(posedge clk) disable iff (rst)
        (killed && !alloc_we) |=> !issued);

    assert_free_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (free_we && !alloc_we) |=> (!req && !issued));

endmodule

// File: rtl/sr_bcast_gen.sv
module sr_bcast_gen
    import sr_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
)(
    input  logic [ENTRIES-1:0]   req,
    input  logic [ENTRIES-1:0]   killed,
    input  logic [ENTRIES-1:0]   is_load,
    input  tag_t                 dest_tag [ENTRIES],
    input  mtx_t                 src_or   [ENTRIES],
    input  logic                 issue_valid,
    input  logic [IDX_W-1:0]     issue_idx,
    input  logic [SR_SLOT_W-1:0] issue_slot,
    output logic                 bc_valid,
    output tag_t                 bc_tag,
    output mtx_t                 bc_mtx,
    output logic [ENTRIES-1:0]   go
);

    always_comb begin
        bc_valid = 1'b0;
        bc_tag   = '0;
        bc_mtx   = '0;
        go       = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (issue_valid && (issue_idx == IDX_W'(e)) && req[e] && !killed[e]) begin
                bc_valid = 1'b1;
                bc_tag   = dest_tag[e];
                bc_mtx   = age_mtx(src_or[e]) | (is_load[e] ? seed_mtx(issue_slot) : '0);
                go[e]    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dep_replay_tracker.sv
module dep_replay_tracker
    import sr_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ROWS    = SR_ROWS,
    parameter int SLOTS   = SR_SLOTS,
    parameter int TAG_W   = SR_TAG_W,
    parameter int SRCS    = SR_SRCS,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int SLOT_W = SR_SLOT_W
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_valid,
    input  logic [IDX_W-1:0]       alloc_idx,
    input  logic [TAG_W-1:0]       alloc_tag,
    input  logic                   alloc_is_load,
    input  logic [SRCS*TAG_W-1:0]  alloc_src_tag,
    input  logic [SRCS-1:0]        alloc_src_rdy,
    input  logic                   issue_valid,
    input  logic [IDX_W-1:0]       issue_idx,
    input  logic [SLOT_W-1:0]      issue_slot,
    input  logic                   free_valid,
    input  logic [IDX_W-1:0]       free_idx,
    input  logic [SLOTS-1:0]       kill_vec,
    output logic [ENTRIES-1:0]     req_vec,
    output logic [ENTRIES-1:0]     issued_vec,
    output logic                   bcast_valid,
    output logic [TAG_W-1:0]       bcast_tag,
    output logic [ROWS*SLOTS-1:0]  bcast_mtx
);

    logic [SR_SRCS-1:0][SR_TAG_W-1:0] src_tags;
    logic [ENTRIES-1:0]               killed;
    logic [ENTRIES-1:0]               load_flag;
    logic [ENTRIES-1:0]               go;
    tag_t                             dest   [ENTRIES];
    mtx_t                             src_or [ENTRIES];
    tag_t                             bc_tag;
    mtx_t                             bc_mtx;

    assign src_tags = alloc_src_tag;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        sr_sched_entry u_ent (
            .clk           (clk),
            .rst           (rst),
            .alloc_we      (alloc_valid && (alloc_idx == IDX_W'(e))),
            .alloc_tag     (alloc_tag),
            .alloc_is_load (alloc_is_load),
            .alloc_src_tag (src_tags),
            .alloc_src_rdy (alloc_src_rdy),
            .issue_go      (go[e]),
            .free_we       (free_valid && (free_idx == IDX_W'(e))),
            .bc_valid      (bcast_valid),
            .bc_tag        (bc_tag),
            .bc_mtx        (bc_mtx),
            .kill_vec      (kill_vec),
            .req           (req_vec[e]),
            .issued        (issued_vec[e]),
            .is_load       (load_flag[e]),
            .dest_tag      (dest[e]),
            .src_or        (src_or[e]),
            .killed        (killed[e])
        );
    end

    sr_bcast_gen #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_bcast (
        .req         (req_vec),
        .killed      (killed),
        .is_load     (load_flag),
        .dest_tag    (dest),
        .src_or      (src_or),
        .issue_valid (issue_valid),
        .issue_idx   (issue_idx),
        .issue_slot  (issue_slot),
        .bc_valid    (bcast_valid),
        .bc_tag      (bc_tag),
        .bc_mtx      (bc_mtx),
        .go          (go)
    );

    assign bcast_tag = bc_tag;
    assign bcast_mtx = bc_mtx;

    assert_bcast_needs_issue_R2: assert property (@(posedge clk) disable iff (rst)
        bcast_valid |-> issue_valid);

    assert_bcast_sets_issued_R2: assert property (@(posedge clk) disable iff (rst)
        (bcast_valid && !(alloc_valid && alloc_idx == issue_idx)
                     && !(free_valid && free_idx == issue_idx))
        |=> issued_vec[$past(issue_idx)]);

endmodule

// File: tb/test_dep_replay_tracker.sv
`timescale 1ns/1ps
module test_dep_replay_tracker;

    logic       clk = 1'b0;
    logic       rst;
    logic       alloc_valid;
    logic [1:0] alloc_idx;
    logic [3:0] alloc_tag;
    logic       alloc_is_load;
    logic [7:0] alloc_src_tag;
    logic [1:0] alloc_src_rdy;
    logic       issue_valid;
    logic [1:0] issue_idx;
    logic       issue_slot;
    logic       free_valid;
    logic [1:0] free_idx;
    logic [1:0] kill_vec;
    logic [3:0] req_vec;
    logic [3:0] issued_vec;
    logic       bcast_valid;
    logic [3:0] bcast_tag;
    logic [5:0] bcast_mtx;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [3:0] req;
        logic [3:0] iss;
        string      rq;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    dep_replay_tracker i_dep_replay_tracker (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_idx(alloc_idx), .alloc_tag(alloc_tag),
        .alloc_is_load(alloc_is_load), .alloc_src_tag(alloc_src_tag), .alloc_src_rdy(alloc_src_rdy),
        .issue_valid(issue_valid), .issue_idx(issue_idx), .issue_slot(issue_slot),
        .free_valid(free_valid), .free_idx(free_idx), .kill_vec(kill_vec),
        .req_vec(req_vec), .issued_vec(issued_vec),
        .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .bcast_mtx(bcast_mtx)
    );

    // Monitor: compares registered state one edge after the driven cycle.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (req_vec !== e.req || issued_vec !== e.iss) begin
                fails++;
                $display("FAIL %s req=%b iss=%b expected req=%b iss=%b",
                         e.rq, req_vec, issued_vec, e.req, e.iss);
            end
        end
    end

    task automatic idle();
        alloc_valid = 0; alloc_idx = 0; alloc_tag = 0; alloc_is_load = 0;
        alloc_src_tag = 0; alloc_src_rdy = 0;
        issue_valid = 0; issue_idx = 0; issue_slot = 0;
        free_valid = 0; free_idx = 0; kill_vec = 0;
    endtask

    task automatic alloc(input logic [1:0] idx, input logic [3:0] tag, input logic ld,
                         input logic [3:0] t0, input logic [3:0] t1, input logic [1:0] rdy);
        alloc_valid = 1; alloc_idx = idx; alloc_tag = tag; alloc_is_load = ld;
        alloc_src_tag = {t1, t0}; alloc_src_rdy = rdy;
    endtask

    task automatic issue(input logic [1:0] idx, input logic slot);
        issue_valid = 1; issue_idx = idx; issue_slot = slot;
    endtask

    // Check broadcast now (combinational), queue state expected after the edge.
    task automatic tick(input logic chk_bc, input logic ebv, input logic [3:0] etag,
                        input logic [5:0] emtx, input string bq,
                        input logic [3:0] ereq, input logic [3:0] eiss, input string rq);
        #1;
        if (chk_bc) begin
            checks++;
            if (bcast_valid !== ebv || (ebv && (bcast_tag !== etag || bcast_mtx !== emtx))) begin
                fails++;
                $display("FAIL %s bv=%b tag=%0d mtx=%b expected bv=%b tag=%0d mtx=%b",
                         bq, bcast_valid, bcast_tag, bcast_mtx, ebv, etag, emtx);
            end
        end
        sb.push_back('{req: ereq, iss: eiss, rq: rq});
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        checks++;
        if (req_vec !== 4'b0 || issued_vec !== 4'b0 || bcast_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 req=%b iss=%b bv=%b expected 0000 0000 0",
                     req_vec, issued_vec, bcast_valid);
        end

        // Allocation: E0 load tag1, E1 needs tag1, E2 independent, E3 needs tag2.
        alloc(0, 1, 1, 0, 0, 2'b11); tick(0, 0, 0, 0, "", 4'b0001, 4'b0000, "R2 alloc ready");
        alloc(1, 2, 0, 1, 0, 2'b10); tick(0, 0, 0, 0, "", 4'b0001, 4'b0000, "R2 alloc waiting");
        alloc(2, 3, 0, 0, 0, 2'b11); tick(0, 0, 0, 0, "", 4'b0101, 4'b0000, "R2 alloc E2");
        alloc(3, 4, 0, 2, 0, 2'b10); tick(0, 0, 0, 0, "", 4'b0101, 4'b0000, "R2 alloc E3");
        // R2: issue of a non-requesting entry is ignored.
        issue(1, 0); tick(1, 0, 0, 0, "R2 ignored issue", 4'b0101, 4'b0000, "R2 ignored issue state");
        // Cycle t: load on slot 1 seeds bit 1 (R3); E1 wakes (R4).
        issue(0, 1); tick(1, 1, 1, 6'b000010, "R3 load seed", 4'b0110, 4'b0001, "R4 wake E1");
        // t+1: E1 passes the bit aged to row 1 (R4, R5).
        issue(1, 0); tick(1, 1, 2, 6'b001000, "R4 transitive", 4'b1100, 4'b0011, "R4 wake E3");
        // t+2: E3 carries it at row 2 (R5).
        issue(3, 0); tick(1, 1, 4, 6'b100000, "R5 row2", 4'b0100, 4'b1011, "R2 E3 issued");
        // t+3: kill slot 1 hits E1 and E3 (R6); E2 issues unaffected (R7).
        issue(2, 0); kill_vec = 2'b10;
        tick(1, 1, 3, 6'b000000, "R7 independent issue", 4'b0000, 4'b0101, "R6 R7 selective kill");

        // Replay: reload E0 (R10 overwrite) and rebroadcast tag1 on slot 0 (R11).
        alloc(0, 1, 1, 0, 0, 2'b11); tick(0, 0, 0, 0, "", 4'b0001, 4'b0100, "R10 realloc");
        issue(0, 0); tick(1, 1, 1, 6'b000001, "R3 slot0 seed", 4'b0010, 4'b0101, "R11 rewake");
        tick(0, 0, 0, 0, "", 4'b0010, 4'b0101, "R5 idle s+1");
        tick(0, 0, 0, 0, "", 4'b0010, 4'b0101, "R5 idle s+2");
        kill_vec = 2'b10; tick(0, 0, 0, 0, "", 4'b0010, 4'b0101, "R6 wrong column");
        // s+4: bit already dropped (R8): kill on slot 0 misses, broadcast empty.
        issue(1, 0); kill_vec = 2'b01;
        tick(1, 1, 2, 6'b000000, "R8 dropped bit", 4'b1000, 4'b0111, "R8 hit no kill");

        // R9: kill in the same cycle as issue.
        alloc(0, 1, 1, 0, 0, 2'b11); tick(0, 0, 0, 0, "", 4'b1001, 4'b0110, "R10 realloc E0");
        alloc(2, 3, 0, 1, 0, 2'b10); tick(0, 0, 0, 0, "", 4'b1001, 4'b0010, "R10 realloc E2");
        issue(0, 0); tick(1, 1, 1, 6'b000001, "R3 seed u", 4'b1100, 4'b0011, "R4 wake E2");
        tick(0, 0, 0, 0, "", 4'b1100, 4'b0011, "R5 idle u+1");
        tick(0, 0, 0, 0, "", 4'b1100, 4'b0011, "R5 idle u+2");
        issue(2, 0); kill_vec = 2'b01;
        tick(1, 0, 0, 0, "R9 kill beats issue", 4'b1000, 4'b0011, "R9 not issued");

        // R10: free.
        free_valid = 1; free_idx = 3; tick(0, 0, 0, 0, "", 4'b0000, 4'b0011, "R10 free E3");
        free_valid = 1; free_idx = 1; tick(0, 0, 0, 0, "", 4'b0000, 4'b0001, "R10 free E1");

        repeat (2) @(posedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule